// File: doc/BRIEF.md
# I2C Master Receive Buffer and Clock Stretch Control

This block sits between the bit-level shift engine of an I2C master and the software-visible receive path. Each time the engine finishes a byte it pulses a strobe. The block keeps that byte in a small receive store and raises a data-ready flag. It also decides whether SCL must be held low so that no further byte arrives before software has room for it. The store is either one entry or two entries deep, chosen at run time by a control bit. Software takes a byte by pulsing a clear strobe. Each clear removes the oldest byte, and a waiting second byte moves forward at once.

A control register also offers a pin bypass mode, in which software sets the SCL and SDA line states directly. Reading the register does not return the two written line bits. In their place it returns the synchronised SCL pin level and a bus-busy flag. The bus-busy flag is tracked from START and STOP conditions seen on the pins. Both line outputs are open-drain enables, where 1 means pull the line low.

Top module: `i2c_rx_stretch`

## Requirements
- R1: After reset, control bits 7 and 4..0 are 0, rx_ready, overrun, bus_busy, scl_oe and sda_oe are 0, and with both pins high ctl_rdata reads 8'h40.
- R2: A byte_valid pulse into an empty store makes rx_ready 1 and rx_data equal to the byte on the following cycle.
- R3: With control bit 7 = 1 (one-entry mode), scl_oe is 1 from the cycle rx_ready rises until the cycle after rx_clear is pulsed.
- R4: With control bit 7 = 0 (two-entry mode), the stretch hold is active only while both entries are occupied. With one entry held and eng_scl_low = 0, scl_oe is 0.
- R5: A pulse on rx_clear removes the oldest byte on the next cycle. If a second byte was held, rx_ready stays 1 and rx_data shows that byte. A clear with nothing stored has no effect.
- R6: With control bit 4 = 1 (bypass), scl_oe equals the inverse of written bit 6 and sda_oe equals the inverse of written bit 5. The engine requests are ignored.
- R7: With bypass off, scl_oe = eng_scl_low OR stretch hold, and sda_oe = eng_sda_low.
- R8: ctl_rdata bit 6 returns the SCL pin level delayed through the synchronizer (two cycles by default), never the written value.
- R9: ctl_rdata bit 5 and bus_busy become 1 after SDA falls while SCL is high (START), and become 0 after SDA rises while SCL is high (STOP). SDA changes while SCL is low do not affect them.
- R10: A byte_valid pulse that arrives when every entry allowed by the mode is full is dropped. The stored bytes stay unchanged and overrun is set and remains set until reset.
- R11: ctl_rdata bits 7, 4 and 3..0 return the values last written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe from the shift engine: byte complete |
| byte_data | input | DATA_W | Completed byte |
| eng_scl_low | input | 1 | Shift engine requests SCL low |
| eng_sda_low | input | 1 | Shift engine requests SDA low |
| scl_pin | input | 1 | SCL line level |
| sda_pin | input | 1 | SDA line level |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| rx_clear | input | 1 | Clear strobe: take the oldest received byte |
| ctl_rdata | output | 8 | Control register readback |
| rx_data | output | DATA_W | Oldest stored byte |
| rx_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Sticky dropped-byte flag |
| bus_busy | output | 1 | Bus busy, between START and STOP |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest state to reach is the two-entry store filled in two-entry mode. Only that state raises the stretch hold there, and only a clear taken in that state shows a byte advancing. The bench reaches it with two strobes issued with no clear between them. It then clears twice and checks the hold, the data and the flag after each step. It also forces an overrun by sending a second strobe in one-entry mode, and it checks that the two-entry run before that never set the overrun flag.

// File: rtl/i2c_rxs_pkg.sv
package i2c_rxs_pkg;
   localparam int unsigned CTL_W = 8;

   // Control register layout; software decodes these positions.
   typedef struct packed {
      logic       single;   // bit 7: 1 = one-entry store
      logic       fscl;     // bit 6: forced SCL level (bypass)
      logic       fsda;     // bit 5: forced SDA level (bypass)
      logic       bypass;   // bit 4: software owns the lines
      logic [3:0] aux;      // bits 3..0: stored, read back
   } ctl_t;
endpackage

// File: rtl/rxs_line_sync.sv
module rxs_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_pin,
   input  logic sda_pin,
   output logic scl_s,
   output logic sda_s,
   output logic bus_busy
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              sda_d;
   logic              start_det, stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_pin};
         sda_q <= {sda_q[STAGES-2:0], sda_pin};
         sda_d <= sda_s;
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign start_det = scl_s &  sda_d & ~sda_s;
   assign stop_det  = scl_s & ~sda_d &  sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_busy <= 1'b0;
      else if (start_det) bus_busy <= 1'b1;
      else if (stop_det)  bus_busy <= 1'b0;
   end

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_s) && scl_s) |=> bus_busy); // R9
   AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_s) && scl_s) |=> !bus_busy); // R9
endmodule

// File: rtl/rxs_rx_buffer.sv
module rxs_rx_buffer #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              clear,
   output logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              hold,
   output logic              overrun
);
   if (DATA_W < 1) begin : g_bad_width
      $error("rxs_rx_buffer: DATA_W must be positive");
   end

   localparam logic [1:0] FULL2 = 2'd2;

   logic [DATA_W-1:0] slot0, slot1;
   logic [1:0]        cnt, cap, cnt_after;
   logic              pop, accept;

   assign cap       = single ? 2'd1 : FULL2;
   assign pop       = clear && (cnt != 2'd0);
   assign cnt_after = cnt - {1'b0, pop};
   assign accept    = push && (cnt_after < cap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot0   <= '0;
         slot1   <= '0;
         cnt     <= 2'd0;
         overrun <= 1'b0;
      end else begin
         if (pop) slot0 <= slot1;
         if (accept) begin
            if (cnt_after == 2'd0) slot0 <= push_data;
            else                   slot1 <= push_data;
         end
         cnt     <= cnt_after + {1'b0, accept};
         overrun <= overrun | (push & ~accept);
      end
   end

   assign rx_ready = (cnt != 2'd0);
   assign rx_data  = slot0;
   assign hold     = single ? (cnt != 2'd0) : (cnt == FULL2);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL2); // R10
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && cnt == 2'd1 && !push) |=> !rx_ready); // R5
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt == FULL2 && !clear) |=> ($stable(rx_data) && overrun)); // R10
endmodule

// File: rtl/i2c_rx_stretch.sv
module i2c_rx_stretch
   import i2c_rxs_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              eng_scl_low,
   input  logic              eng_sda_low,
   input  logic              scl_pin,
   input  logic              sda_pin,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              rx_clear,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              overrun,
   output logic              bus_busy,
   output logic              scl_oe,
   output logic              sda_oe
);
   ctl_t ctl;
   logic scl_s, sda_s, hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl <= '{single: 1'b0, fscl: 1'b1, fsda: 1'b1, bypass: 1'b0, aux: 4'h0};
      else if (ctl_wr) ctl <= ctl_t'(ctl_wdata);
   end

   rxs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_pin  (scl_pin),
      .sda_pin  (sda_pin),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .bus_busy (bus_busy)
   );

   rxs_rx_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .single    (ctl.single),
      .push      (byte_valid),
      .push_data (byte_data),
      .clear     (rx_clear),
      .rx_ready  (rx_ready),
      .rx_data   (rx_data),
      .hold      (hold),
      .overrun   (overrun)
   );

   always_comb begin
      if (ctl.bypass) begin
         scl_oe = ~ctl.fscl;
         sda_oe = ~ctl.fsda;
      end else begin
         scl_oe = eng_scl_low | hold;
         sda_oe = eng_sda_low;
      end
   end

   assign ctl_rdata = {ctl.single, scl_s, bus_busy, ctl.bypass, ctl.aux};

   AST_SINGLE_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.bypass && ctl.single && rx_ready) |-> scl_oe); // R3
   AST_BYPASS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.bypass && ctl.fscl && ctl.fsda) |-> (!scl_oe && !sda_oe)); // R6
   AST_DOUBLE_ONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.bypass && !ctl.single && !eng_scl_low && rx_ready && !hold) |-> !scl_oe); // R4
endmodule

// File: tb/i2c_rx_stretch_tb.sv
module i2c_rx_stretch_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic       eng_scl_low = 1'b0, eng_sda_low = 1'b0;
   logic       scl_pin = 1'b1, sda_pin = 1'b1;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       rx_clear = 1'b0;
   logic [7:0] ctl_rdata, rx_data;
   logic       rx_ready, overrun, bus_busy, scl_oe, sda_oe;
   int         checks = 0, fails = 0;

   always #5 clk = ~clk;

   i2c_rx_stretch u_dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
      .scl_pin(scl_pin), .sda_pin(sda_pin), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .rx_clear(rx_clear), .ctl_rdata(ctl_rdata), .rx_data(rx_data),
      .rx_ready(rx_ready), .overrun(overrun), .bus_busy(bus_busy),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   // {write value[18:11], scl pin[10], exp scl_oe[9], exp sda_oe[8], exp rdata[7:0]}
   localparam logic [18:0] VEC [0:6] = '{
      {8'h10, 1'b1, 1'b1, 1'b1, 8'h50},
      {8'h70, 1'b1, 1'b0, 1'b0, 8'h50},
      {8'h50, 1'b0, 1'b0, 1'b1, 8'h10},
      {8'h2F, 1'b1, 1'b0, 1'b0, 8'h4F},
      {8'h85, 1'b0, 1'b0, 1'b0, 8'h85},
      {8'h3A, 1'b1, 1'b1, 1'b0, 8'h5A},
      {8'h00, 1'b1, 1'b0, 1'b0, 8'h40}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic strobe(input logic [7:0] b);
      byte_valid = 1'b1; byte_data = b;
      @(negedge clk); byte_valid = 1'b0;
   endtask

   task automatic pop();
      rx_clear = 1'b1;
      @(negedge clk); rx_clear = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      wait_n(2);
      // R1 reset state
      chk("R1 rdata", ctl_rdata, 8'h40);
      chk("R1 flags", {3'b0, rx_ready, overrun, bus_busy, scl_oe, sda_oe}, 8'h00);
      rst_n = 1'b1;
      wait_n(1);

      // Table: R6 bypass, R8 SCL readback, R11 field readback, R7 idle engine
      for (int i = 0; i < 7; i++) begin
         wr_ctl(VEC[i][18:11]);
         scl_pin = VEC[i][10];
         wait_n(3);
         chk("R6 scl_oe", {7'b0, scl_oe}, {7'b0, VEC[i][9]});
         chk("R6 sda_oe", {7'b0, sda_oe}, {7'b0, VEC[i][8]});
         chk("R8/R11 rdata", ctl_rdata, VEC[i][7:0]);
      end
      scl_pin = 1'b1;
      wait_n(3);

      // Two-entry mode: R2, R4, R5
      wr_ctl(8'h00);
      strobe(8'hA5);
      chk("R2 ready", {7'b0, rx_ready}, 8'h01);
      chk("R2 data", rx_data, 8'hA5);
      chk("R4 one entry no hold", {7'b0, scl_oe}, 8'h00);
      strobe(8'h3C);
      chk("R4 two entries hold", {7'b0, scl_oe}, 8'h01);
      chk("R5 head kept", rx_data, 8'hA5);
      pop();
      chk("R5 advance ready", {7'b0, rx_ready}, 8'h01);
      chk("R5 advance data", rx_data, 8'h3C);
      chk("R4 release", {7'b0, scl_oe}, 8'h00);
      pop();
      chk("R5 empty", {7'b0, rx_ready}, 8'h00);
      pop();
      chk("R5 clear on empty", {7'b0, rx_ready}, 8'h00);
      chk("R10 no overrun in normal flow", {7'b0, overrun}, 8'h00);

      // R7 engine passthrough
      eng_scl_low = 1'b1; eng_sda_low = 1'b1;
      wait_n(1);
      chk("R7 engine", {6'b0, scl_oe, sda_oe}, 8'h03);
      eng_scl_low = 1'b0; eng_sda_low = 1'b0;
      wait_n(1);
      chk("R7 engine off", {6'b0, scl_oe, sda_oe}, 8'h00);

      // One-entry mode: R3, R10
      wr_ctl(8'h80);
      strobe(8'h11);
      chk("R3 hold", {7'b0, scl_oe}, 8'h01);
      strobe(8'h22);
      chk("R10 overrun", {7'b0, overrun}, 8'h01);
      chk("R10 data kept", rx_data, 8'h11);
      pop();
      chk("R3 release", {7'b0, scl_oe}, 8'h00);
      chk("R3 ready clear", {7'b0, rx_ready}, 8'h00);
      chk("R10 sticky", {7'b0, overrun}, 8'h01);

      // R6 bypass ignores engine
      wr_ctl(8'h70);
      eng_scl_low = 1'b1; eng_sda_low = 1'b1;
      wait_n(1);
      chk("R6 engine ignored", {6'b0, scl_oe, sda_oe}, 8'h00);
      eng_scl_low = 1'b0; eng_sda_low = 1'b0;
      wr_ctl(8'h00);

      // R9 START / STOP
      sda_pin = 1'b0; wait_n(4);
      chk("R9 start busy", {7'b0, bus_busy}, 8'h01);
      chk("R9 rdata busy", ctl_rdata & 8'h20, 8'h20);
      sda_pin = 1'b1; wait_n(4);
      chk("R9 stop idle", {7'b0, bus_busy}, 8'h00);
      scl_pin = 1'b0; wait_n(4);
      sda_pin = 1'b0; wait_n(4);
      chk("R9 sda with scl low", {7'b0, bus_busy}, 8'h00);
      sda_pin = 1'b1; wait_n(2);
      scl_pin = 1'b1; wait_n(4);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule